// File: doc/BRIEF.md
# Guarded Nonvolatile Data Store Controller

This block connects a byte-wide CPU register port to a small on-chip data store, which is modelled here as a register array. Software loads an address register and a data register, then uses a control register to start a read or a write. A read copies the selected cell into the data register. A write copies the data register into the selected cell.

A write needs a two-step unlock. Software first sets an arm bit. The hardware drops that bit by itself after a short window. A write strobe that arrives while the bit is still set starts a write. A strobe that arrives at any other time does nothing.

While a write is running, the write-enable bit stays high as a busy flag for a fixed number of cycles. The block also drives a level-sensitive ready interrupt. This interrupt is high whenever its local enable and the global enable are both set and no write is in progress. A separate input reports that flash self-programming is in progress; while it is high, write strobes are refused.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: After reset, the address, data and control registers all read as zero, the arm window is idle and `ready_irq` is low.
- R2: The control register (select 2) has ready interrupt enable at bit 3, arm at bit 2, write enable/busy at bit 1 and read strobe at bit 0. Bits 7..4 and bit 0 always read as zero. Select 0 is the address register, select 1 is the data register and select 3 reads as zero.
- R3: A control write with bit 2 set and bit 1 clear sets the arm bit. The arm bit reads as one for exactly 4 cycles and then clears by itself.
- R4: A write strobe (control bit 1 written as one) while the arm bit is clear starts no write: the busy bit stays zero and the cell keeps its value.
- R5: A write strobe while the arm bit is set starts a write, including on the last cycle of the window. The write stores the data register into the cell selected by the address register, sets the busy bit and clears the arm bit.
- R6: A write strobe that arrives after the arm window has expired is ignored.
- R7: A single control write that sets bit 2 and bit 1 together, while the arm bit is clear, neither arms the window nor starts a write.
- R8: While `flash_prog_busy` is high, a write strobe is ignored even when the arm bit is set.
- R9: The busy bit stays at one for exactly 16 cycles (WRITE_CYCLES) after the write starts and then clears by itself.
- R10: While the busy bit is set, software writes to the address and data registers are ignored, and so are read strobes.
- R11: A read strobe (control bit 1 clear, bit 0 set) while not busy loads the selected cell into the data register. The new value is visible from the second clock edge after the strobe is captured.
- R12: `ready_irq` is a registered level. It equals (bit 3 and `glob_int_en` and not busy) as sampled one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read value of the selected register |
| glob_int_en | input | 1 | Global interrupt enable |
| flash_prog_busy | input | 1 | Flash self-programming in progress |
| ready_irq | output | 1 | Level-sensitive ready interrupt |

## Verification
The bench probes each edge of the arm window.

- A strobe on the fourth cycle after arming must write. A strobe on the fifth must not. An off-by-one counter would either refuse the first case or let the second one through.
- Strobes without arming, strobes in the same access that arms, and strobes during flash programming must all leave the cell unchanged when it is read back. A design that ignored any of these guards would corrupt the stored byte.
- The busy flag is sampled on its sixteenth and seventeenth cycles. During busy, address, data and read accesses are tried; a design that did not freeze them would return the wrong byte afterwards.
- The interrupt is checked for its one-cycle lag and for falling while a write is in progress.

// File: rtl/nvmg_pkg.sv
package nvmg_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int BIT_RD  = 0;
  localparam int BIT_WR  = 1;
  localparam int BIT_ARM = 2;
  localparam int BIT_RIE = 3;
  localparam int BUS_W   = 8;
endpackage

// File: rtl/nvmg_countdown.sv
module nvmg_countdown #(
  parameter int unsigned COUNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic kill,
  output logic active
);
  localparam int CW = $clog2(COUNT + 1);
  localparam logic [CW-1:0] LOAD = CW'(COUNT);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (kill || (active && cnt == LAST)) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt <= cnt - LAST;
    end
  end

  // R3 / R9: a running count ends exactly after its last cycle
  a_r3_last_cycle_ends: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == LAST && !start) |=> !active);
  a_r9_start_activates: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && cnt == LOAD));
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0 && cnt <= LOAD));
endmodule

// File: rtl/nvmg_store.sv
module nvmg_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    if (rd_en) rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvmg_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WIN_CYCLES   = 4,
  parameter int WRITE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       glob_int_en,
  input  logic       flash_prog_busy,
  output logic       ready_irq
);
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;
  logic [BUS_W-1:0]  cell_rd;
  logic              rie_q;
  logic              rd_pend;
  logic              arm;
  logic              busy;

  logic wr_ctrl, strobe_w, strobe_r, arm_req, accept_w, accept_r;

  always_comb begin
    wr_ctrl  = reg_we && (reg_sel == SEL_CTRL);
    strobe_w = wr_ctrl && reg_wdata[BIT_WR];
    strobe_r = wr_ctrl && reg_wdata[BIT_RD];
    arm_req  = wr_ctrl && reg_wdata[BIT_ARM] && !reg_wdata[BIT_WR];
    accept_w = strobe_w && arm && !busy && !flash_prog_busy;
    accept_r = strobe_r && !busy && !accept_w;
  end

  nvmg_countdown #(.COUNT(WIN_CYCLES)) u_window (
    .clk(clk), .rst(rst), .start(arm_req), .kill(accept_w), .active(arm)
  );

  nvmg_countdown #(.COUNT(WRITE_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(accept_w), .kill(1'b0), .active(busy)
  );

  nvmg_store #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_store (
    .clk(clk), .wr_en(accept_w), .wr_addr(addr_q), .wr_data(data_q),
    .rd_en(accept_r), .rd_addr(addr_q), .rd_data(cell_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      rie_q     <= 1'b0;
      rd_pend   <= 1'b0;
      ready_irq <= 1'b0;
    end else begin
      rd_pend   <= accept_r;
      ready_irq <= rie_q && glob_int_en && !busy;
      if (wr_ctrl) rie_q <= reg_wdata[BIT_RIE];
      if (reg_we && reg_sel == SEL_ADDR && !busy) addr_q <= reg_wdata[ADDR_W-1:0];
      if (rd_pend) data_q <= cell_rd;
      else if (reg_we && reg_sel == SEL_DATA && !busy) data_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
      SEL_DATA: reg_rdata = data_q;
      SEL_CTRL: begin
        reg_rdata[BIT_RIE] = rie_q;
        reg_rdata[BIT_ARM] = arm;
        reg_rdata[BIT_WR]  = busy;
      end
      default: reg_rdata = '0;
    endcase
  end

  a_r5_accept_starts_busy: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> (busy && !arm));
  a_r4_unarmed_no_write: assert property (@(posedge clk) disable iff (rst)
    (strobe_w && !arm && !busy) |=> !busy);
  a_r7_joint_bits_inert: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && reg_wdata[BIT_ARM] && reg_wdata[BIT_WR] && !arm && !busy) |=> (!busy && !arm));
  a_r8_flash_blocks: assert property (@(posedge clk) disable iff (rst)
    (strobe_w && flash_prog_busy && !busy) |=> !busy);
  a_r10_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_sel == SEL_ADDR) |=> $stable(addr_q));
  a_r12_irq_low_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !ready_irq);
endmodule

// File: tb/nvm_guard_ctrl_tb_top.sv
module nvm_guard_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_NONE = 2'd3;
  localparam int NVEC = 6;
  // {address, data} pairs written through the full unlock sequence
  localparam logic [13:0] VEC [NVEC] = '{
    {6'd0, 8'hA5}, {6'd1, 8'h00}, {6'd17, 8'hFF},
    {6'd42, 8'h5C}, {6'd62, 8'h81}, {6'd63, 8'h3E}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic glob_int_en = 1'b0, flash_prog_busy = 1'b0;
  logic ready_irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_guard_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_int_en(glob_int_en),
    .flash_prog_busy(flash_prog_busy), .ready_irq(ready_irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    reg_sel = sel; reg_wdata = val; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic read_cell(input logic [5:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    wr(S_ADDR, {2'b00, a});
    wr(S_CTRL, 8'h01);
    idle(1);
    peek(S_DATA, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    peek(S_ADDR, v); check("R1 addr reset", v, 8'h00);
    peek(S_DATA, v); check("R1 data reset", v, 8'h00);
    peek(S_CTRL, v); check("R1 ctrl reset", v, 8'h00);
    check("R1 irq reset", {7'd0, ready_irq}, 8'h00);

    // R5 R9 R11 table walk: unlock, write, wait busy, read back
    for (int i = 0; i < NVEC; i++) begin
      wr(S_ADDR, {2'b00, VEC[i][13:8]});
      wr(S_DATA, VEC[i][7:0]);
      wr(S_CTRL, 8'h04);
      wr(S_CTRL, 8'h02);
      peek(S_CTRL, v); check("R5 write started", v, 8'h02);
      idle(15);
      peek(S_CTRL, v); check("R9 busy on last cycle", v, 8'h02);
      idle(1);
      peek(S_CTRL, v); check("R9 busy cleared", v, 8'h00);
      wr(S_DATA, ~VEC[i][7:0]);
      wr(S_CTRL, 8'h01);
      peek(S_DATA, v); check("R11 not yet loaded", v, ~VEC[i][7:0]);
      idle(1);
      peek(S_DATA, v); check("R11 read back", v, VEC[i][7:0]);
    end

    // R2 reserved bits and read strobe bit read zero; other selects
    wr(S_CTRL, 8'hF1);
    peek(S_CTRL, v); check("R2 reserved zero", v, 8'h00);
    wr(S_CTRL, 8'h08);
    peek(S_CTRL, v); check("R2 rie at bit3", v, 8'h08);
    peek(S_NONE, v); check("R2 select 3 zero", v, 8'h00);
    wr(S_CTRL, 8'h00);

    // R3 arm window length
    wr(S_CTRL, 8'h04);
    peek(S_CTRL, v); check("R3 arm cycle1", v, 8'h04);
    idle(3);
    peek(S_CTRL, v); check("R3 arm cycle4", v, 8'h04);
    idle(1);
    peek(S_CTRL, v); check("R3 arm expired", v, 8'h00);

    // R4 strobe without arm
    wr(S_ADDR, 8'h00);
    wr(S_DATA, 8'h99);
    wr(S_CTRL, 8'h02);
    peek(S_CTRL, v); check("R4 no busy", v, 8'h00);
    read_cell(6'd0, 8'hA5, "R4 cell kept");

    // R6 late strobe
    wr(S_DATA, 8'h99);
    wr(S_CTRL, 8'h04);
    idle(4);
    wr(S_CTRL, 8'h02);
    peek(S_CTRL, v); check("R6 late strobe ignored", v, 8'h00);
    read_cell(6'd0, 8'hA5, "R6 cell kept");

    // R5 strobe on last window cycle
    wr(S_DATA, 8'h5A);
    wr(S_CTRL, 8'h04);
    idle(3);
    wr(S_CTRL, 8'h02);
    peek(S_CTRL, v); check("R5 last window cycle accepted", v, 8'h02);
    idle(16);
    read_cell(6'd0, 8'h5A, "R5 cell written");

    // R7 both bits in one access
    wr(S_DATA, 8'h77);
    wr(S_CTRL, 8'h06);
    peek(S_CTRL, v); check("R7 joint bits inert", v, 8'h00);
    read_cell(6'd0, 8'h5A, "R7 cell kept");

    // R8 flash busy
    flash_prog_busy = 1'b1;
    wr(S_DATA, 8'h66);
    wr(S_CTRL, 8'h04);
    wr(S_CTRL, 8'h02);
    peek(S_CTRL, v); check("R8 strobe refused", v, 8'h04);
    flash_prog_busy = 1'b0;
    idle(5);
    read_cell(6'd0, 8'h5A, "R8 cell kept");

    // R10 register freeze during busy
    wr(S_DATA, 8'h11);
    wr(S_CTRL, 8'h04);
    wr(S_CTRL, 8'h02);
    wr(S_ADDR, 8'h01);
    wr(S_DATA, 8'h22);
    peek(S_ADDR, v); check("R10 addr frozen", v, 8'h00);
    peek(S_DATA, v); check("R10 data frozen", v, 8'h11);
    wr(S_CTRL, 8'h01);
    idle(1);
    peek(S_DATA, v); check("R10 read ignored", v, 8'h11);
    idle(16);
    read_cell(6'd0, 8'h11, "R10 cell written");
    read_cell(6'd1, 8'h00, "R10 other cell untouched");

    // R12 interrupt level and lag
    glob_int_en = 1'b1;
    wr(S_CTRL, 8'h08);
    check("R12 irq lags", {7'd0, ready_irq}, 8'h00);
    idle(1);
    check("R12 irq high", {7'd0, ready_irq}, 8'h01);
    wr(S_CTRL, 8'h0C);
    wr(S_CTRL, 8'h0A);
    check("R12 irq before busy seen", {7'd0, ready_irq}, 8'h01);
    idle(1);
    check("R12 irq low while busy", {7'd0, ready_irq}, 8'h00);
    idle(15);
    check("R12 irq low last busy edge", {7'd0, ready_irq}, 8'h00);
    idle(1);
    check("R12 irq back high", {7'd0, ready_irq}, 8'h01);
    glob_int_en = 1'b0;
    idle(1);
    check("R12 irq off by global", {7'd0, ready_irq}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule